// File: doc/BRIEF.md
# Serial-Bus Single-Register Control Slave

This block is a two-wire serial-bus (I2C) slave that owns one 8-bit system register for a power-and-tone controller. A host writes one data byte to set six control outputs: current-limit style, tone arming, continuous tone, line-drop compensation, high-voltage select and output enable. A host read returns a different byte. It carries three echoed control bits, two live fault flags and three constant-zero test positions. The read repeats for as long as the host acknowledges.

SCL and SDA come from the pads as plain levels. The block synchronises them into the system clock domain and finds edges, start and stop there. The system clock must run at least eight times faster than SCL. SDA is driven open-drain through a single pull-down output. The low bit of the 7-bit address follows a pin. A second, reserved address is also answered. While the undervoltage-lockout input is high, the register is forced to zero and the slave never pulls SDA low.

Top module: `sysreg_i2c_slave`

## Requirements
- R1: After reset, all six control outputs are 0 and `sda_pull` is 0.
- R2: The slave acknowledges an address byte only in two cases. The first is when its upper seven bits equal 0001010 with the last of those bits replaced by `addr_sel`. The second is when they equal the reserved address 0001000. The eighth bit selects read (1) or write (0). Any other address gets no acknowledge, and the slave ignores the bus until the next start.
- R3: A written data byte maps bits to outputs as follows. Bit 7 goes to `cur_static`, bit 6 to `tone_arm`, bit 5 to `tone_always`, bit 4 to `drop_comp`, bit 3 to `volt_high` and bit 2 to `out_enable`. Bits 1:0 have no effect. Outputs change only on a completed write or during lockout.
- R4: The slave pulls SDA low for the ninth clock after a matching address byte and after the data byte of a write. It only starts pulling while SCL is low.
- R5: The read byte, sent MSB first, is laid out as follows. Bits 7:5 are 0. Bits 4:2 are `drop_comp`, `volt_high` and `out_enable`. Bit 1 is `over_temp` and bit 0 is `over_load`, both sampled when the byte starts.
- R6: After each read byte, an acknowledge (SDA low) from the host on the ninth clock starts another byte. A not-acknowledge ends the read, and SDA is released.
- R7: A write takes one data byte only. Further bytes in the same transfer are not acknowledged and change nothing.
- R8: While `uvlo` is 1, the control outputs are 0 from the next cycle on. `sda_pull` is 0 from the next cycle on, and no byte is acknowledged.
- R9: Start is SDA falling while SCL is high, and stop is SDA rising while SCL is high. A start or stop in the middle of a byte abandons the transfer without writing. A following start is decoded as a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level from the pad |
| sda_in | input | 1 | Bus data level from the pad |
| addr_sel | input | 1 | Selects the low address bit |
| uvlo | input | 1 | Undervoltage lockout active |
| over_temp | input | 1 | Live over-temperature flag |
| over_load | input | 1 | Live overload flag |
| sda_pull | output | 1 | 1 pulls SDA low (open drain) |
| cur_static | output | 1 | Static (1) or pulsed (0) current limiting |
| tone_arm | output | 1 | Arms the tone output stage |
| tone_always | output | 1 | Continuous tone request |
| drop_comp | output | 1 | Line-drop voltage compensation |
| volt_high | output | 1 | High (1) or low (0) output voltage |
| out_enable | output | 1 | Power output enable |

## Verification
A wrong bit counter or a wrong state shows at the port as an acknowledge pulled on the wrong clock, or as a missing one. It can also show as a read bit shifted by one position. Each of these is visible within the same nine-clock byte. A wrong commit point changes the control outputs after an aborted or over-long write. A wrong reset or lockout path leaves an output set, or SDA pulled, one cycle after `uvlo` rises. The directed tasks sample each acknowledge slot and each read bit in the high phase of SCL. They read the control outputs after every transfer.

// File: rtl/sr_i2c_pkg.sv
`timescale 1ns/1ps
package sr_i2c_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK, S_SKIP
   } sr_state_t;

   typedef struct packed {
      logic cur_static;
      logic tone_arm;
      logic tone_always;
      logic drop_comp;
      logic volt_high;
      logic out_enable;
   } sr_ctl_t;

   localparam int unsigned SR_CTL_W = $bits(sr_ctl_t);
endpackage

// File: rtl/sr_line_sync.sv
`timescale 1ns/1ps
module sr_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sr_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_chain, sda_chain;
   logic scl_prev, sda_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_chain <= '1;
         sda_chain <= '1;
         scl_prev  <= 1'b1;
         sda_prev  <= 1'b1;
      end else begin
         scl_chain <= {scl_chain[STAGES-2:0], scl_in};
         sda_chain <= {sda_chain[STAGES-2:0], sda_in};
         scl_prev  <= scl_chain[STAGES-1];
         sda_prev  <= sda_chain[STAGES-1];
      end
   end

   assign scl_lvl   = scl_chain[STAGES-1];
   assign sda_lvl   = sda_chain[STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_prev;
   assign scl_fall  = ~scl_lvl & scl_prev;
   assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/sr_bus_engine.sv
`timescale 1ns/1ps
module sr_bus_engine
   import sr_i2c_pkg::*;
#(
   parameter int unsigned  BYTE_W   = 8,
   parameter int unsigned  CTL_W    = 6,
   parameter logic [5:0]   ADDR_HI  = 6'b000101,
   parameter logic [6:0]   RESV_ADR = 7'b0001000,
   parameter bit           RESV_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_lvl,
   input  logic             sda_lvl,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic             uvlo,
   input  logic             addr_sel,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic             wr_en,
   output logic [CTL_W-1:0] wr_data,
   output logic             sda_pull
);
   localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

   if (BYTE_W != 8) begin : g_bad_byte
      $error("sr_bus_engine: BYTE_W must be 8 for a 7-bit address");
   end
   if (CTL_W > BYTE_W) begin : g_bad_ctl
      $error("sr_bus_engine: CTL_W exceeds BYTE_W");
   end

   sr_state_t         state;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] rx_sh, tx_sh;
   logic              is_read, host_ack;
   logic              user_hit, resv_hit, addr_hit;

   assign user_hit = (rx_sh[7:1] == {ADDR_HI, addr_sel});
   if (RESV_EN) begin : g_resv
      assign resv_hit = (rx_sh[7:1] == RESV_ADR);
   end else begin : g_no_resv
      assign resv_hit = 1'b0;
   end
   assign addr_hit = user_hit | resv_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         cnt      <= '0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         is_read  <= 1'b0;
         host_ack <= 1'b0;
         wr_en    <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (uvlo) begin
            state <= S_SKIP;
         end else if (start_det) begin
            state <= S_ADDR;
            cnt   <= '0;
         end else if (stop_det) begin
            state <= S_IDLE;
         end else begin
            case (state)
               S_ADDR: begin
                  if (scl_rise) begin
                     rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST) begin
                     is_read <= rx_sh[0];
                     state   <= addr_hit ? S_AACK : S_SKIP;
                  end
               end
               S_AACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (is_read) begin
                        tx_sh <= rd_byte;
                        state <= S_RDAT;
                     end else begin
                        state <= S_WDAT;
                     end
                  end
               end
               S_WDAT: begin
                  if (scl_rise) begin
                     rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST) begin
                     wr_en <= 1'b1;
                     state <= S_WACK;
                  end
               end
               S_WACK: begin
                  if (scl_fall) state <= S_SKIP;
               end
               S_RDAT: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == LAST) begin
                        cnt   <= '0;
                        state <= S_RACK;
                     end else begin
                        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                     end
                  end
               end
               S_RACK: begin
                  if (scl_rise) begin
                     host_ack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (host_ack) begin
                        tx_sh <= rd_byte;
                        state <= S_RDAT;
                     end else begin
                        state <= S_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign wr_data  = rx_sh[BYTE_W-1 -: CTL_W];
   assign sda_pull = (state == S_AACK) || (state == S_WACK) ||
                     ((state == S_RDAT) && !tx_sh[BYTE_W-1]);

   // R8: lockout releases the line from the next cycle
   p_uvlo_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      uvlo |=> !sda_pull);
   // R4: the slave begins pulling only while SCL is low
   p_pull_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_lvl);
   // R9: a start always restarts address decoding
   p_start_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det && !uvlo) |=> state == S_ADDR);
   // R9: a stop always returns to idle
   p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det && !uvlo) |=> state == S_IDLE);
endmodule

// File: rtl/sr_ctl_reg.sv
`timescale 1ns/1ps
module sr_ctl_reg
   import sr_i2c_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CTL_W  = SR_CTL_W,
   parameter int unsigned ECHO_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              uvlo,
   input  logic              wr_en,
   input  logic [CTL_W-1:0]  wr_data,
   input  logic              over_temp,
   input  logic              over_load,
   output sr_ctl_t           ctl,
   output logic [BYTE_W-1:0] rd_byte
);
   localparam int unsigned PAD_W = BYTE_W - ECHO_W - 2;

   if (CTL_W != SR_CTL_W) begin : g_bad_ctl
      $error("sr_ctl_reg: CTL_W must match the control struct");
   end
   if (ECHO_W + 2 > BYTE_W || ECHO_W > CTL_W) begin : g_bad_echo
      $error("sr_ctl_reg: read layout does not fit the byte");
   end

   sr_ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (uvlo)   ctl_q <= '0;
      else if (wr_en)  ctl_q <= sr_ctl_t'(wr_data);
   end

   assign ctl     = ctl_q;
   assign rd_byte = {{PAD_W{1'b0}}, ctl_q[ECHO_W-1:0], over_temp, over_load};

   // R3: the register only moves on a committed write or lockout
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !uvlo) |=> $stable(ctl_q));
   // R8: lockout clears the register
   p_uvlo_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      uvlo |=> (ctl_q == '0));
endmodule

// File: rtl/sysreg_i2c_slave.sv
`timescale 1ns/1ps
module sysreg_i2c_slave
   import sr_i2c_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BYTE_W      = 8,
   parameter logic [5:0]  ADDR_HI     = 6'b000101,
   parameter logic [6:0]  RESV_ADR    = 7'b0001000,
   parameter bit          RESV_EN     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   input  logic addr_sel,
   input  logic uvlo,
   input  logic over_temp,
   input  logic over_load,
   output logic sda_pull,
   output logic cur_static,
   output logic tone_arm,
   output logic tone_always,
   output logic drop_comp,
   output logic volt_high,
   output logic out_enable
);
   localparam int unsigned CTL_W = SR_CTL_W;

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic wr_en;
   logic [CTL_W-1:0]  wr_data;
   logic [BYTE_W-1:0] rd_byte;
   sr_ctl_t ctl;

   sr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
   );

   sr_bus_engine #(
      .BYTE_W(BYTE_W), .CTL_W(CTL_W), .ADDR_HI(ADDR_HI),
      .RESV_ADR(RESV_ADR), .RESV_EN(RESV_EN)
   ) u_engine (
      .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
      .stop_det(stop_det), .uvlo(uvlo), .addr_sel(addr_sel),
      .rd_byte(rd_byte), .wr_en(wr_en), .wr_data(wr_data),
      .sda_pull(sda_pull)
   );

   sr_ctl_reg #(.BYTE_W(BYTE_W), .CTL_W(CTL_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .wr_en(wr_en),
      .wr_data(wr_data), .over_temp(over_temp), .over_load(over_load),
      .ctl(ctl), .rd_byte(rd_byte)
   );

   assign cur_static  = ctl.cur_static;
   assign tone_arm    = ctl.tone_arm;
   assign tone_always = ctl.tone_always;
   assign drop_comp   = ctl.drop_comp;
   assign volt_high   = ctl.volt_high;
   assign out_enable  = ctl.out_enable;
endmodule

// File: tb/sysreg_i2c_slave_test.sv
`timescale 1ns/1ps
module sysreg_i2c_slave_test;
   localparam int Q = 400;  // quarter SCL period in ns

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda_m = 1'b1;
   logic addr_sel = 1'b0, uvlo = 1'b0, over_temp = 1'b0, over_load = 1'b0;
   logic sda_pull, cur_static, tone_arm, tone_always, drop_comp, volt_high, out_enable;
   wire  sda_line = sda_m & ~sda_pull;
   int   checks = 0, failures = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   sysreg_i2c_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
      .addr_sel(addr_sel), .uvlo(uvlo), .over_temp(over_temp),
      .over_load(over_load), .sda_pull(sda_pull), .cur_static(cur_static),
      .tone_arm(tone_arm), .tone_always(tone_always), .drop_comp(drop_comp),
      .volt_high(volt_high), .out_enable(out_enable)
   );

   function automatic logic [5:0] outs();
      return {cur_static, tone_arm, tone_always, drop_comp, volt_high, out_enable};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b0; #(Q); scl = 1'b0; #(Q);
   endtask
   task automatic bus_restart();
      sda_m = 1'b1; #(Q); scl = 1'b1; #(Q); bus_start();
   endtask
   task automatic bus_stop();
      sda_m = 1'b0; #(Q); scl = 1'b1; #(Q); sda_m = 1'b1; #(Q);
   endtask
   task automatic bus_bit(input logic b, output logic seen);
      sda_m = b; #(Q); scl = 1'b1; #(Q); seen = sda_line; #(Q); scl = 1'b0; #(Q);
   endtask
   task automatic send_byte(input logic [7:0] b, output logic acked);
      logic s;
      for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
      bus_bit(1'b1, s);
      acked = ~s;
   endtask
   task automatic recv_byte(output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, s); b[i] = s; end
   endtask
   task automatic do_write(input logic [6:0] a, input logic [7:0] d,
                           output logic aa, output logic da);
      bus_start(); send_byte({a, 1'b0}, aa);
      if (aa) send_byte(d, da); else da = 1'b0;
      bus_stop();
   endtask

   task automatic t_reset();
      check("R1 outputs after reset", outs(), 6'b000000);
      check("R1 sda_pull after reset", sda_pull, 1'b0);
   endtask

   task automatic t_write_basic();
      logic aa, da;
      do_write(7'b0001010, 8'hAC, aa, da);
      check("R4 address ack", aa, 1'b1);
      check("R4 data ack", da, 1'b1);
      check("R3 write 0xAC", outs(), 6'b101011);
   endtask

   task automatic t_test_bits();
      logic aa, da;
      do_write(7'b0001010, 8'h03, aa, da);
      check("R3 low bits have no effect", outs(), 6'b000000);
      do_write(7'b0001010, 8'h5C, aa, da);
      check("R3 write 0x5C", outs(), 6'b010111);
   endtask

   task automatic t_read_single();
      logic aa, s; logic [7:0] b;
      over_temp = 1'b1; over_load = 1'b0;
      bus_start(); send_byte(8'b00010101, aa);
      check("R2 read address ack", aa, 1'b1);
      recv_byte(b);
      check("R5 read byte echo and flags", b, 8'b00011110);
      bus_bit(1'b1, s);
      bus_stop();
      check("R6 line released after NACK", sda_pull, 1'b0);
   endtask

   task automatic t_read_multi();
      logic aa, s; logic [7:0] b;
      bus_start(); send_byte(8'b00010101, aa);
      recv_byte(b);
      check("R5 first read byte", b, 8'b00011110);
      over_temp = 1'b0; over_load = 1'b1;
      bus_bit(1'b0, s);
      recv_byte(b);
      check("R6 second byte after host ACK", b, 8'b00011101);
      bus_bit(1'b1, s);
      bus_stop();
      check("R6 released after final NACK", sda_pull, 1'b0);
      over_load = 1'b0;
   endtask

   task automatic t_addr_pin();
      logic aa, da;
      addr_sel = 1'b1;
      do_write(7'b0001010, 8'hFC, aa, da);
      check("R2 other pin address not acked", aa, 1'b0);
      check("R2 unmatched write ignored", outs(), 6'b010111);
      do_write(7'b0001011, 8'h04, aa, da);
      check("R2 pin-selected address acked", aa, 1'b1);
      check("R3 write 0x04", outs(), 6'b000001);
   endtask

   task automatic t_reserved();
      logic aa, da;
      do_write(7'b0001000, 8'h08, aa, da);
      check("R2 reserved address acked", aa, 1'b1);
      check("R2 reserved address writes", outs(), 6'b000010);
      do_write(7'b0110000, 8'hFC, aa, da);
      check("R2 foreign address not acked", aa, 1'b0);
      check("R2 foreign write ignored", outs(), 6'b000010);
   endtask

   task automatic t_single_byte();
      logic aa, da, xa;
      bus_start(); send_byte(8'b00010110, aa);
      send_byte(8'h10, da);
      send_byte(8'hFC, xa);
      bus_stop();
      check("R7 first data byte acked", da, 1'b1);
      check("R7 extra byte not acked", xa, 1'b0);
      check("R7 extra byte not written", outs(), 6'b000100);
   endtask

   task automatic t_abort();
      logic aa, da, s;
      bus_start(); send_byte(8'b00010110, aa);
      for (int i = 0; i < 4; i++) bus_bit(1'b1, s);
      bus_stop();
      check("R9 stop mid-byte leaves register", outs(), 6'b000100);
      bus_start(); send_byte(8'b00010110, aa);
      for (int i = 0; i < 3; i++) bus_bit(1'b1, s);
      bus_restart();
      send_byte(8'b00010110, aa);
      check("R9 address after repeated start acked", aa, 1'b1);
      send_byte(8'h84, da);
      bus_stop();
      check("R9 write after repeated start", outs(), 6'b100001);
   endtask

   task automatic t_uvlo();
      logic aa, da;
      uvlo = 1'b1;
      repeat (3) @(negedge clk);
      check("R8 outputs cleared in lockout", outs(), 6'b000000);
      do_write(7'b0001011, 8'hFC, aa, da);
      check("R8 no ack in lockout", aa, 1'b0);
      check("R8 outputs held at zero", outs(), 6'b000000);
      bus_start(); send_byte(8'b00010111, aa); bus_stop();
      check("R8 no read ack in lockout", aa, 1'b0);
      uvlo = 1'b0;
      repeat (3) @(negedge clk);
      do_write(7'b0001011, 8'h24, aa, da);
      check("R8 ack returns after lockout", aa, 1'b1);
      check("R3 write 0x24", outs(), 6'b001001);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write_basic();
      t_test_bits();
      t_read_single();
      t_read_multi();
      t_addr_pin();
      t_reserved();
      t_single_byte();
      t_abort();
      t_uvlo();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1900000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule